// File: doc/BRIEF.md
# Interlocked Lock Release Unit

This unit carries out two privileged lock-release operations: one that gives up a secondary lock and one that gives up the per-address-space local lock. A release succeeds only when the lock is shown as held in the caller's held-locks indicator word and the waiter word that sits next to the lockword is zero. A successful release is a single atomic compare-and-clear of the aligned doubleword that holds the lockword and its companion word. The unit then clears the matching indicator bit and zeroes general register 13.

When any condition fails, the unit takes a software slow path. Register 12 receives the updated instruction address with its top bit cleared. Register 13 receives a word fetched from a fixed negative offset below the lock-interface table base. The instruction address is redirected to that word, with its addressing-mode bit left out. A simplified mode always sends the request down the slow path. A lockword address that is not doubleword aligned raises a specification exception and suppresses the operation.

The unit is started with a one-cycle `start` pulse and reports completion with a one-cycle `done` pulse. It talks to memory through a request/acknowledge port that offers word reads and an atomic doubleword compare-and-clear. The condition code is not an output and is never touched.

Top module: `lrel_unit`

## Requirements
- R1: Secondary release (`op_local`=0) succeeds when indicator bit 1 is set, the lockword at `lock_addr` equals `op1_word`, and the word at `lock_addr`+4 is zero. On success both words become zero, `gr13_wdata`=0 is written, and the indicator is written back with only bit 1 cleared. There is no redirect.
- R2: A secondary release whose lockword differs, whose companion word is non-zero, or whose indicator bit 1 is clear leaves both memory words unchanged and takes the slow path. When bit 1 is clear, no atomic access is issued.
- R3: Local release (`op_local`=1) succeeds when indicator bit 0 is set, bit 1 is clear, and the companion word is zero. The lockword value is not compared. The doubleword is zeroed, `gr13_wdata`=0 is written, and the indicator is written back with only bit 0 cleared.
- R4: A local release with bit 0 clear, with bit 1 set, or with a non-zero companion word leaves memory unchanged and takes the slow path. Only the companion-word case issues an atomic access.
- R5: On the slow path, register 12 receives `next_ia` with bit 31 cleared, and register 13 receives the word at `table_base`-4 (secondary) or `table_base`-12 (local). `redir_valid` pulses with `redir_addr` equal to that word with bit 31 cleared. The indicator is not written.
- R6: With `simple_mode`=1 the slow path is taken whatever the conditions are, no atomic access is made, and memory is unchanged.
- R7: If `lock_addr[2:0]` is non-zero, `spec_exc` pulses with `done`. No register, indicator, redirect or memory access takes place.
- R8: Each accepted `start` yields exactly one single-cycle `done`. A `start` that arrives while an operation is in progress is ignored. `mem_req` and `mem_addr` stay stable until `mem_ack`.
- R9: After reset, `done`, `mem_req`, `spec_exc`, `ind_we`, `gr12_we`, `gr13_we` and `redir_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one release operation |
| op_local | input | 1 | 1 = local-lock release, 0 = secondary-lock release |
| simple_mode | input | 1 | Force the slow path |
| lock_addr | input | W | Byte address of the lockword (register 11 for secondary) |
| op1_word | input | W | First-operand word, compared with the secondary lockword |
| ind_word | input | W | Held-locks indicator (bit 0 local, bit 1 secondary) |
| next_ia | input | W | Updated instruction address |
| table_base | input | W | Lock-interface table base address |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_atomic | output | 1 | 1 = compare-and-clear doubleword, 0 = word read |
| mem_addr | output | W | Memory byte address |
| mem_cmp_en | output | 1 | Require the lockword to equal `mem_cmp` |
| mem_cmp | output | W | Compare value for the lockword |
| mem_ack | input | 1 | Memory response strobe |
| mem_rdata | input | W | Read data |
| mem_hit | input | 1 | Atomic conditions met and doubleword cleared |
| done | output | 1 | Operation complete (one cycle) |
| spec_exc | output | 1 | Specification exception (with done) |
| ind_we | output | 1 | Indicator write strobe |
| ind_wdata | output | W | Updated indicator word |
| gr12_we | output | 1 | Register 12 write strobe |
| gr12_wdata | output | W | Register 12 value |
| gr13_we | output | 1 | Register 13 write strobe |
| gr13_wdata | output | W | Register 13 value |
| redir_valid | output | 1 | Instruction-address redirect strobe |
| redir_addr | output | W | New instruction address |

## Verification
The hardest outcome to reach is a release whose indicator checks pass but whose atomic access reports a miss. The precheck has already committed the unit to the atomic path, and it must then fall back to the table fetch without leaving any trace in memory. The bench reaches this by loading its memory model with a mismatching lockword or a non-zero companion word while the indicator claims the lock is held. It then confirms that the slow-path registers are written and that both memory words keep their values. The bench also counts atomic accesses, so it can show that the simplified, precheck-fail and misaligned cases never touch memory atomically.

// File: rtl/lrel_pkg.sv
package lrel_pkg;
  localparam int LOCAL_BIT   = 0;
  localparam int SEC_BIT     = 1;
  localparam int SEC_TBL_OFS = 4;
  localparam int LOC_TBL_OFS = 12;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ATOM  = 2'd1,
    ST_FETCH = 2'd2
  } lrel_state_e;
endpackage

// File: rtl/lrel_gate.sv
module lrel_gate #(
  parameter int W = 32
) (
  input  logic         op_local,
  input  logic [W-1:0] lock_addr,
  input  logic [W-1:0] ind_word,
  output logic         misalign,
  output logic         pre_ok
);
  import lrel_pkg::*;

  always_comb begin
    misalign = |lock_addr[2:0];
    if (op_local)
      pre_ok = ind_word[LOCAL_BIT] & ~ind_word[SEC_BIT];
    else
      pre_ok = ind_word[SEC_BIT];
  end
endmodule

// File: rtl/lrel_slow.sv
module lrel_slow #(
  parameter int W = 32
) (
  input  logic         op_local,
  input  logic [W-1:0] table_base,
  input  logic [W-1:0] next_ia,
  input  logic [W-1:0] rdata,
  output logic [W-1:0] fetch_addr,
  output logic [W-1:0] link_val,
  output logic [W-1:0] target
);
  import lrel_pkg::*;

  localparam logic [W-1:0] SEC_OFS = W'(SEC_TBL_OFS);
  localparam logic [W-1:0] LOC_OFS = W'(LOC_TBL_OFS);

  always_comb begin
    fetch_addr = table_base - (op_local ? LOC_OFS : SEC_OFS);
    link_val   = {1'b0, next_ia[W-2:0]};
    target     = {1'b0, rdata[W-2:0]};
  end
endmodule

// File: rtl/lrel_ctrl.sv
module lrel_ctrl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_local,
  input  logic         simple_mode,
  input  logic [W-1:0] lock_addr,
  input  logic [W-1:0] op1_word,
  input  logic [W-1:0] ind_word,
  input  logic [W-1:0] next_ia,
  input  logic [W-1:0] table_base,
  input  logic         misalign,
  input  logic         pre_ok,
  input  logic [W-1:0] fetch_addr,
  input  logic [W-1:0] link_val,
  input  logic [W-1:0] target,
  input  logic         mem_ack,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_hit,
  output logic         l_op_local,
  output logic [W-1:0] l_table_base,
  output logic [W-1:0] l_next_ia,
  output logic         mem_req,
  output logic         mem_atomic,
  output logic [W-1:0] mem_addr,
  output logic         mem_cmp_en,
  output logic [W-1:0] mem_cmp,
  output logic         done,
  output logic         spec_exc,
  output logic         ind_we,
  output logic [W-1:0] ind_wdata,
  output logic         gr12_we,
  output logic [W-1:0] gr12_wdata,
  output logic         gr13_we,
  output logic [W-1:0] gr13_wdata,
  output logic         redir_valid,
  output logic [W-1:0] redir_addr
);
  import lrel_pkg::*;

  lrel_state_e  state;
  logic [W-1:0] l_lock_addr;
  logic [W-1:0] l_op1;
  logic [W-1:0] l_ind;
  logic [W-1:0] bit_mask;

  always_comb begin
    mem_req    = (state != ST_IDLE);
    mem_atomic = (state == ST_ATOM);
    mem_addr   = (state == ST_ATOM) ? l_lock_addr : fetch_addr;
    mem_cmp_en = (state == ST_ATOM) && !l_op_local;
    mem_cmp    = l_op1;
    bit_mask   = '0;
    bit_mask[l_op_local ? LOCAL_BIT : SEC_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      l_op_local   <= 1'b0;
      l_lock_addr  <= '0;
      l_op1        <= '0;
      l_ind        <= '0;
      l_next_ia    <= '0;
      l_table_base <= '0;
      done         <= 1'b0;
      spec_exc     <= 1'b0;
      ind_we       <= 1'b0;
      ind_wdata    <= '0;
      gr12_we      <= 1'b0;
      gr12_wdata   <= '0;
      gr13_we      <= 1'b0;
      gr13_wdata   <= '0;
      redir_valid  <= 1'b0;
      redir_addr   <= '0;
    end else begin
      done        <= 1'b0;
      spec_exc    <= 1'b0;
      ind_we      <= 1'b0;
      gr12_we     <= 1'b0;
      gr13_we     <= 1'b0;
      redir_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            l_op_local   <= op_local;
            l_lock_addr  <= lock_addr;
            l_op1        <= op1_word;
            l_ind        <= ind_word;
            l_next_ia    <= next_ia;
            l_table_base <= table_base;
            if (misalign) begin
              done     <= 1'b1;
              spec_exc <= 1'b1;
            end else if (simple_mode || !pre_ok) begin
              state <= ST_FETCH;
            end else begin
              state <= ST_ATOM;
            end
          end
        end
        ST_ATOM: begin
          if (mem_ack) begin
            if (mem_hit) begin
              done       <= 1'b1;
              gr13_we    <= 1'b1;
              gr13_wdata <= '0;
              ind_we     <= 1'b1;
              ind_wdata  <= l_ind & ~bit_mask;
              state      <= ST_IDLE;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            done        <= 1'b1;
            gr12_we     <= 1'b1;
            gr12_wdata  <= link_val;
            gr13_we     <= 1'b1;
            gr13_wdata  <= mem_rdata;
            redir_valid <= 1'b1;
            redir_addr  <= target;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lrel_unit.sv
module lrel_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_local,
  input  logic         simple_mode,
  input  logic [W-1:0] lock_addr,
  input  logic [W-1:0] op1_word,
  input  logic [W-1:0] ind_word,
  input  logic [W-1:0] next_ia,
  input  logic [W-1:0] table_base,
  output logic         mem_req,
  output logic         mem_atomic,
  output logic [W-1:0] mem_addr,
  output logic         mem_cmp_en,
  output logic [W-1:0] mem_cmp,
  input  logic         mem_ack,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_hit,
  output logic         done,
  output logic         spec_exc,
  output logic         ind_we,
  output logic [W-1:0] ind_wdata,
  output logic         gr12_we,
  output logic [W-1:0] gr12_wdata,
  output logic         gr13_we,
  output logic [W-1:0] gr13_wdata,
  output logic         redir_valid,
  output logic [W-1:0] redir_addr
);
  logic         misalign, pre_ok;
  logic         l_op_local;
  logic [W-1:0] l_table_base, l_next_ia;
  logic [W-1:0] fetch_addr, link_val, target;

  lrel_gate #(.W(W)) u_gate (
    .op_local(op_local), .lock_addr(lock_addr), .ind_word(ind_word),
    .misalign(misalign), .pre_ok(pre_ok)
  );

  lrel_slow #(.W(W)) u_slow (
    .op_local(l_op_local), .table_base(l_table_base), .next_ia(l_next_ia),
    .rdata(mem_rdata), .fetch_addr(fetch_addr), .link_val(link_val),
    .target(target)
  );

  lrel_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op_local(op_local),
    .simple_mode(simple_mode), .lock_addr(lock_addr), .op1_word(op1_word),
    .ind_word(ind_word), .next_ia(next_ia), .table_base(table_base),
    .misalign(misalign), .pre_ok(pre_ok), .fetch_addr(fetch_addr),
    .link_val(link_val), .target(target), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_hit(mem_hit), .l_op_local(l_op_local),
    .l_table_base(l_table_base), .l_next_ia(l_next_ia),
    .mem_req(mem_req), .mem_atomic(mem_atomic), .mem_addr(mem_addr),
    .mem_cmp_en(mem_cmp_en), .mem_cmp(mem_cmp), .done(done),
    .spec_exc(spec_exc), .ind_we(ind_we), .ind_wdata(ind_wdata),
    .gr12_we(gr12_we), .gr12_wdata(gr12_wdata), .gr13_we(gr13_we),
    .gr13_wdata(gr13_wdata), .redir_valid(redir_valid),
    .redir_addr(redir_addr)
  );
endmodule

// File: rtl/lrel_unit_chk.sv
module lrel_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         mem_req,
  input logic         mem_atomic,
  input logic [W-1:0] mem_addr,
  input logic         mem_ack,
  input logic         done,
  input logic         spec_exc,
  input logic         ind_we,
  input logic         gr12_we,
  input logic [W-1:0] gr12_wdata,
  input logic         gr13_we,
  input logic [W-1:0] gr13_wdata,
  input logic         redir_valid,
  input logic [W-1:0] redir_addr
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_atomic)));

  assert_spec_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    spec_exc |-> (done && !gr12_we && !gr13_we && !ind_we && !redir_valid));

  assert_slow_regs_R5: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> (done && gr12_we && gr13_we && !ind_we &&
                     !gr12_wdata[W-1] && !redir_addr[W-1]));

  assert_success_R1: assert property (@(posedge clk) disable iff (rst)
    ind_we |-> (done && gr13_we && gr13_wdata == '0 && !redir_valid));

  assert_reset_idle_R9: assert property (@(posedge clk)
    $past(rst) |-> (!done && !mem_req && !ind_we && !redir_valid));
endmodule

bind lrel_unit lrel_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_atomic(mem_atomic),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .done(done), .spec_exc(spec_exc),
  .ind_we(ind_we), .gr12_we(gr12_we), .gr12_wdata(gr12_wdata),
  .gr13_we(gr13_we), .gr13_wdata(gr13_wdata), .redir_valid(redir_valid),
  .redir_addr(redir_addr)
);

// File: tb/lrel_unit_tb.sv
module lrel_unit_tb;
  localparam int W = 32;
  localparam logic [31:0] TBASE = 32'h80;
  localparam logic [31:0] SEC_TW = 32'h8000_0A00;
  localparam logic [31:0] LOC_TW = 32'h0000_0B04;
  localparam logic [31:0] NIA = 32'h8000_4446;

  typedef struct packed {
    logic        loc;
    logic        simp;
    logic [7:0]  addr;
    logic [31:0] op1;
    logic [31:0] ind;
    logic [31:0] lockw;
    logic [31:0] nextw;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 8'h10, 32'hCAFE0001, 32'hA3, 32'hCAFE0001, 32'h0},
    '{1'b0, 1'b0, 8'h10, 32'hCAFE0001, 32'hA3, 32'hCAFE0002, 32'h0},
    '{1'b0, 1'b0, 8'h10, 32'hCAFE0001, 32'hA2, 32'hCAFE0001, 32'h5},
    '{1'b0, 1'b0, 8'h10, 32'hCAFE0001, 32'hA1, 32'hCAFE0001, 32'h0},
    '{1'b1, 1'b0, 8'h20, 32'h0,        32'h51, 32'h00001234, 32'h0},
    '{1'b1, 1'b0, 8'h20, 32'h0,        32'h53, 32'h00001234, 32'h0},
    '{1'b1, 1'b0, 8'h20, 32'h0,        32'h50, 32'h00001234, 32'h0},
    '{1'b1, 1'b0, 8'h20, 32'h0,        32'h51, 32'h00001234, 32'h9},
    '{1'b0, 1'b1, 8'h10, 32'hCAFE0001, 32'hA2, 32'hCAFE0001, 32'h0},
    '{1'b1, 1'b1, 8'h20, 32'h0,        32'h51, 32'h00001234, 32'h0},
    '{1'b0, 1'b0, 8'h14, 32'hCAFE0001, 32'hA2, 32'hCAFE0001, 32'h0},
    '{1'b1, 1'b0, 8'h24, 32'h0,        32'h51, 32'h00001234, 32'h0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, op_local = 1'b0, simple_mode = 1'b0;
  logic [W-1:0] lock_addr = '0, op1_word = '0, ind_word = '0;
  logic [W-1:0] next_ia = NIA, table_base = TBASE;
  logic mem_req, mem_atomic, mem_cmp_en;
  logic [W-1:0] mem_addr, mem_cmp;
  logic mem_ack = 1'b0, mem_hit = 1'b0;
  logic [W-1:0] mem_rdata = '0;
  logic done, spec_exc, ind_we, gr12_we, gr13_we, redir_valid;
  logic [W-1:0] ind_wdata, gr12_wdata, gr13_wdata, redir_addr;

  logic [31:0] mem [0:63];
  int atom_cnt = 0;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  lrel_unit #(.W(W)) u_dut (.*);

  always @(posedge clk) begin
    int idx;
    if (rst) begin
      mem_ack <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        idx = int'(mem_addr[7:2]);
        if (mem_atomic) begin
          atom_cnt++;
          if ((!mem_cmp_en || mem[idx] == mem_cmp) && mem[idx+1] == 32'h0) begin
            mem_hit <= 1'b1;
            mem[idx] <= 32'h0;
            mem[idx+1] <= 32'h0;
          end else begin
            mem_hit <= 1'b0;
          end
        end else begin
          mem_rdata <= mem[idx];
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Runs one operation; returns results seen at the done cycle.
  task automatic run_op(input logic loc, input logic simp, input logic [31:0] addr,
                        input logic [31:0] op1, input logic [31:0] ind,
                        input logic poke_busy,
                        output logic s_spec, output logic s_ind_we,
                        output logic [31:0] s_ind, output logic s_12we,
                        output logic [31:0] s_12, output logic s_13we,
                        output logic [31:0] s_13, output logic s_rv,
                        output logic [31:0] s_ra, output int n_done);
    int t;
    op_local = loc; simple_mode = simp; lock_addr = addr;
    op1_word = op1; ind_word = ind;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      op_local = ~loc; lock_addr = 32'h28; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 40) begin @(negedge clk); t++; end
    s_spec = spec_exc; s_ind_we = ind_we; s_ind = ind_wdata;
    s_12we = gr12_we; s_12 = gr12_wdata; s_13we = gr13_we; s_13 = gr13_wdata;
    s_rv = redir_valid; s_ra = redir_addr;
    n_done = done ? 1 : 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done) n_done++;
    end
  endtask

  initial begin
    logic s_spec, s_ind_we, s_12we, s_13we, s_rv;
    logic [31:0] s_ind, s_12, s_13, s_ra;
    int nd;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[31] = SEC_TW;
    mem[29] = LOC_TW;

    repeat (3) @(negedge clk);
    // R9: reset state
    check(!done && !mem_req && !spec_exc && !ind_we && !gr12_we && !gr13_we && !redir_valid,
          "R9", "outputs in reset", {25'b0, done, mem_req, spec_exc, ind_we, gr12_we, gr13_we, redir_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !mem_req, "R9", "idle after reset", {30'b0, done, mem_req}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      vec_t c;
      logic spec, pre, succ;
      int ai, a0;
      string rq;
      c = VEC[v];
      ai = int'(c.addr[7:2]);
      mem[ai] = c.lockw;
      if (c.addr[2:0] == 3'b0) mem[ai+1] = c.nextw;
      spec = |c.addr[2:0];
      pre  = c.loc ? (c.ind[0] & ~c.ind[1]) : c.ind[1];
      succ = !spec && !c.simp && pre && (c.loc || c.lockw == c.op1) && c.nextw == 0;
      if (spec)        rq = "R7";
      else if (c.simp) rq = "R6";
      else if (succ)   rq = c.loc ? "R3" : "R1";
      else             rq = c.loc ? "R4" : "R2";
      a0 = atom_cnt;
      run_op(c.loc, c.simp, {24'h0, c.addr}, c.op1, c.ind, 1'b0,
             s_spec, s_ind_we, s_ind, s_12we, s_12, s_13we, s_13, s_rv, s_ra, nd);
      check(nd == 1, "R8", "done count", nd, 1);
      check(s_spec == spec, rq, "spec_exc", {31'b0, s_spec}, {31'b0, spec});
      if (spec) begin
        check(!s_12we && !s_13we && !s_ind_we && !s_rv, rq, "no writes",
              {28'b0, s_12we, s_13we, s_ind_we, s_rv}, 32'h0);
        check(atom_cnt == a0, rq, "no atomic access", atom_cnt - a0, 0);
      end else if (succ) begin
        check(s_ind_we && s_ind == (c.ind & ~(c.loc ? 32'h1 : 32'h2)), rq, "indicator",
              s_ind, c.ind & ~(c.loc ? 32'h1 : 32'h2));
        check(s_13we && s_13 == 0 && !s_rv && !s_12we, rq, "gr13 zero, no redirect", s_13, 32'h0);
        check(mem[ai] == 0 && mem[ai+1] == 0, rq, "doubleword cleared", mem[ai] | mem[ai+1], 32'h0);
      end else begin
        logic [31:0] tw;
        tw = c.loc ? LOC_TW : SEC_TW;
        check(s_12we && s_12 == {1'b0, NIA[30:0]}, "R5", "gr12 link", s_12, {1'b0, NIA[30:0]});
        check(s_13we && s_13 == tw, "R5", "gr13 table word", s_13, tw);
        check(s_rv && s_ra == {1'b0, tw[30:0]}, "R5", "redirect", s_ra, {1'b0, tw[30:0]});
        check(!s_ind_we, rq, "indicator untouched", {31'b0, s_ind_we}, 32'h0);
        check(mem[ai] == c.lockw && mem[ai+1] == c.nextw, rq, "memory unchanged", mem[ai], c.lockw);
        if (c.simp || !pre)
          check(atom_cnt == a0, rq, "no atomic access", atom_cnt - a0, 0);
      end
    end

    // R8: start while busy is ignored
    mem[4] = 32'h77; mem[5] = 32'h0;
    mem[10] = 32'h0; mem[11] = 32'h0;
    begin
      int a0;
      a0 = atom_cnt;
      run_op(1'b0, 1'b0, 32'h10, 32'h77, 32'h2, 1'b1,
             s_spec, s_ind_we, s_ind, s_12we, s_12, s_13we, s_13, s_rv, s_ra, nd);
      check(nd == 1, "R8", "one done for busy start", nd, 1);
      check(atom_cnt == a0 + 1, "R8", "one atomic access", atom_cnt - a0, 1);
      check(s_ind_we && s_ind == 32'h0, "R8", "first op result kept", s_ind, 32'h0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule